// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This block sits on the request path between a bus master and a peripheral register region. The master sees two address windows. In the plain peripheral window, accesses pass straight through. In the alias window, each bit of the peripheral region has its own word address. A write to an alias word changes exactly one bit of the matching peripheral word. It does this through a locked read-modify-write, so software never has to mask bits itself. A read from an alias word returns that one bit in bit 0.

The master side is a valid/ready request channel with a one-cycle response pulse. The block takes one request at a time. The downstream side holds its request until the slave returns an acknowledge, which carries the read data on reads. A lock output marks the two halves of a read-modify-write so that an arbiter keeps other masters off the port between them. An address that falls in neither window is answered with an error flag and never reaches the slave.

Top module: `bitband_xlate`

## Requirements
- R1: An alias address A (window base 0x42000000, size 32 MiB, mapping the 1 MiB region at 0x40000000) targets byte offset (A-0x42000000)>>5 of the region. It uses bit number ((A>>2)&7) of that byte. Downstream it addresses the aligned word 0x40000000 + (byte offset with the low two bits cleared), at bit position 8*(byte offset & 3) + bit number. Example: 0x424A0810 targets bit 4 of word 0x40025040.
- R2: An alias write with write-data bit 0 equal to 1 issues a downstream read of the target word, then a write of that word with only the target bit set.
- R3: An alias write with write-data bit 0 equal to 0 clears only the target bit. Bits 31..1 of the write data have no effect.
- R4: An alias read issues a single downstream read and no write. Its response carries the target bit in bit 0 and zeros in bits 31..1.
- R5: For an alias write, the downstream write is issued in the cycle right after the read is acknowledged. The lock output is high for both accesses.
- R6: An address inside the peripheral region is forwarded unchanged, with its write flag and write data. Read data comes back unchanged, and the error flag is 0.
- R7: An address outside both windows gets a response with the error flag at 1 and data 0. No downstream access is issued.
- R8: The two low bits of an alias address are ignored. Alias addresses that differ only in those bits reach the same bit.
- R9: The ready output is high only while the block is idle, and it drops in the cycle after a request is accepted. The response valid is a one-cycle pulse.
- R10: After reset, ready is 1 and response valid, downstream valid and lock are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Master request valid |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | 32 | Request byte address |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqWdata | input | 32 | Write data |
| respValid | output | 1 | One-cycle response strobe |
| respData | output | 32 | Read data (0 for writes and errors) |
| respErr | output | 1 | Address was outside both windows |
| dnValid | output | 1 | Downstream request, held until acknowledged |
| dnAddr | output | 32 | Downstream word address |
| dnWrite | output | 1 | Downstream write flag |
| dnWdata | output | 32 | Downstream write data |
| dnLock | output | 1 | Keep the downstream port for this master |
| dnAck | input | 1 | Downstream access complete |
| dnRdata | input | 32 | Downstream read data, valid with dnAck |

## Verification
Alias writes are tried on a cleared word, where a set shows up as a single one, and on an all-ones word, where a clear shows up as a single zero. The all-ones case also uses write data whose upper bits are set, which tells bit 0 apart from any other bit. Alias reads are taken at a cleared bit and at a set bit, and at the top bit of the last word of the region, which checks the lane and word arithmetic at the window edge. Alias addresses with non-zero low bits separate the ignored bits from the bit number. Addresses below, above and just past each window check the error path and confirm that no downstream access is issued.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PASS, ST_ARD, ST_AWR, ST_RESP
  } stateT;

  typedef enum logic [1:0] {
    K_ERR, K_PASS, K_ALIAS
  } kindT;

  typedef struct packed {
    logic capture;  // latch request, clear response
    logic ldPass;   // take downstream data as the response
    logic ldBit;    // take the target bit as the response
    logic ldWord;   // hold the word for modification
  } strobeT;
endpackage

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PERI_AW = 20,
  parameter logic [ADDR_W-1:0] PERI_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h4200_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] dnRdata,
  output kindT              decKind,
  output kindT              kind,
  output logic              capWrite,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [DATA_W-1:0] dnWdata,
  output logic [DATA_W-1:0] respData
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int LANE_W = BIT_W - 3;
  localparam int ALIAS_AW = PERI_AW + BIT_W;

  logic inPeri, inAlias;
  logic [ADDR_W-1:0] aliasWordAddr;
  logic [BIT_W-1:0] aliasBit;

  assign inPeri  = reqAddr[ADDR_W-1:PERI_AW] == PERI_BASE[ADDR_W-1:PERI_AW];
  assign inAlias = reqAddr[ADDR_W-1:ALIAS_AW] == ALIAS_BASE[ADDR_W-1:ALIAS_AW];
  assign decKind = inAlias ? K_ALIAS : (inPeri ? K_PASS : K_ERR);

  assign aliasWordAddr = {PERI_BASE[ADDR_W-1:PERI_AW],
                          reqAddr[ALIAS_AW-1:BIT_W+LANE_W],
                          {LANE_W{1'b0}}};
  assign aliasBit = {reqAddr[BIT_W+LANE_W-1:BIT_W], reqAddr[BIT_W-1:LANE_W]};

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg, wordReg;
  logic [BIT_W-1:0]  bitReg;
  logic [DATA_W-1:0] bitMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      bitReg   <= '0;
      kind     <= K_ERR;
      capWrite <= 1'b0;
    end else if (stb.capture) begin
      addrReg  <= (decKind == K_ALIAS) ? aliasWordAddr : reqAddr;
      wdataReg <= reqWdata;
      bitReg   <= aliasBit;
      kind     <= decKind;
      capWrite <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg  <= '0;
      respData <= '0;
    end else begin
      if (stb.capture) respData <= '0;
      if (stb.ldPass)  respData <= dnRdata;
      if (stb.ldBit)   respData <= {{(DATA_W-1){1'b0}}, dnRdata[bitReg]};
      if (stb.ldWord)  wordReg  <= dnRdata;
    end
  end

  assign bitMask = {{(DATA_W-1){1'b0}}, 1'b1} << bitReg;
  assign dnAddr  = addrReg;
  assign dnWdata = (kind == K_ALIAS)
                 ? ((wordReg & ~bitMask) | (wdataReg[0] ? bitMask : '0))
                 : wdataReg;

  // R1
  alias_in_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kind == K_ALIAS) |-> (addrReg[ADDR_W-1:PERI_AW] == PERI_BASE[ADDR_W-1:PERI_AW]));
  // R4
  alias_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldBit |=> (respData[DATA_W-1:1] == '0));
endmodule

// File: rtl/bb_control.sv
module bb_control
  import bb_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  input  kindT   decKind,
  input  kindT   kind,
  input  logic   capWrite,
  input  logic   dnAck,
  output logic   reqReady,
  output logic   respValid,
  output logic   respErr,
  output logic   dnValid,
  output logic   dnWrite,
  output logic   dnLock,
  output strobeT stb
);
  stateT state, nextState;
  logic accept;

  assign accept = reqValid && (state == ST_IDLE);

  always_comb begin
    nextState = state;
    stb = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        stb.capture = 1'b1;
        unique case (decKind)
          K_PASS:  nextState = ST_PASS;
          K_ALIAS: nextState = ST_ARD;
          default: nextState = ST_RESP;
        endcase
      end
      ST_PASS: if (dnAck) begin
        stb.ldPass = !capWrite;
        nextState  = ST_RESP;
      end
      ST_ARD: if (dnAck) begin
        stb.ldBit  = !capWrite;
        stb.ldWord = capWrite;
        nextState  = capWrite ? ST_AWR : ST_RESP;
      end
      ST_AWR: if (dnAck) nextState = ST_RESP;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign reqReady  = (state == ST_IDLE);
  assign respValid = (state == ST_RESP);
  assign respErr   = respValid && (kind == K_ERR);
  assign dnValid   = (state == ST_PASS) || (state == ST_ARD) || (state == ST_AWR);
  assign dnWrite   = ((state == ST_PASS) && capWrite) || (state == ST_AWR);
  assign dnLock    = ((state == ST_ARD) && capWrite) || (state == ST_AWR);

  logic unusedWrite;
  assign unusedWrite = reqWrite & accept;

  // R9
  ready_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);
  // R5
  rmw_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && dnLock && !dnWrite && dnAck) |=> (dnValid && dnWrite && dnLock));
  // R7
  no_dn_on_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    dnValid |-> (kind != K_ERR));
endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PERI_AW = 20,
  parameter logic [ADDR_W-1:0] PERI_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h4200_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic              respErr,
  output logic              dnValid,
  output logic [ADDR_W-1:0] dnAddr,
  output logic              dnWrite,
  output logic [DATA_W-1:0] dnWdata,
  output logic              dnLock,
  input  logic              dnAck,
  input  logic [DATA_W-1:0] dnRdata
);
  strobeT stb;
  kindT decKind, kind;
  logic capWrite;

  bb_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PERI_AW(PERI_AW),
    .PERI_BASE(PERI_BASE), .ALIAS_BASE(ALIAS_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .dnRdata(dnRdata), .decKind(decKind), .kind(kind), .capWrite(capWrite),
    .dnAddr(dnAddr), .dnWdata(dnWdata), .respData(respData)
  );

  bb_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .decKind(decKind), .kind(kind), .capWrite(capWrite), .dnAck(dnAck),
    .reqReady(reqReady), .respValid(respValid), .respErr(respErr),
    .dnValid(dnValid), .dnWrite(dnWrite), .dnLock(dnLock), .stb(stb)
  );
endmodule

// File: tb/bitband_xlate_bench.sv
module bitband_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic reqReady, respValid, respErr, dnValid, dnWrite, dnLock;
  logic [31:0] respData, dnAddr, dnWdata;
  logic dnAck = 0;
  logic [31:0] dnRdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitband_xlate u_bitband_xlate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .respValid(respValid), .respData(respData), .respErr(respErr),
    .dnValid(dnValid), .dnAddr(dnAddr), .dnWrite(dnWrite), .dnWdata(dnWdata),
    .dnLock(dnLock), .dnAck(dnAck), .dnRdata(dnRdata)
  );

  int checkCount = 0, failCount = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // downstream slave model
  logic [31:0] mem [logic [31:0]];
  int cyc = 0, opCount = 0, wrCount = 0, rdCyc = 0, wrCyc = 0;
  logic rdLock = 0, wrLock = 0;
  logic [31:0] lastWrAddr = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dnValid && !dnAck) begin
      opCount <= opCount + 1;
      dnAck <= 1'b1;
      if (dnWrite) begin
        mem[dnAddr] = dnWdata;
        wrCount <= wrCount + 1;
        wrCyc <= cyc; wrLock <= dnLock; lastWrAddr <= dnAddr;
      end else begin
        dnRdata <= mem.exists(dnAddr) ? mem[dnAddr] : 32'h0;
        rdCyc <= cyc; rdLock <= dnLock;
      end
    end else begin
      dnAck <= 1'b0;
    end
  end

  // scoreboard
  logic [31:0] expData [$];
  logic expErr [$];
  string expTag [$];
  int respCount = 0;

  always @(negedge clk) begin
    if (respValid) begin
      if (expData.size() == 0) begin
        check(0, "R9 unexpected response", respData, 0);
      end else begin
        logic [31:0] d; logic e; string t;
        d = expData.pop_front(); e = expErr.pop_front(); t = expTag.pop_front();
        check(respData == d, {t, " data"}, respData, d);
        check(respErr == e, {t, " err"}, {31'b0, respErr}, {31'b0, e});
      end
      respCount++;
    end
  end

  function automatic logic [31:0] aliasOf(input logic [31:0] byteAddr, input int bitNum);
    return 32'h4200_0000 + ((byteAddr - 32'h4000_0000) << 5) + (bitNum << 2);
  endfunction

  task automatic send(input logic [31:0] a, input logic w, input logic [31:0] wd,
                      input logic [31:0] ed, input logic ee, input string tag);
    int start;
    expData.push_back(ed); expErr.push_back(ee); expTag.push_back(tag);
    while (!reqReady) @(negedge clk);
    start = respCount;
    reqAddr = a; reqWrite = w; reqWdata = wd; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    check(reqReady == 0, "R9 ready low while busy", {31'b0, reqReady}, 0);
    while (respCount == start) @(negedge clk);
    @(negedge clk);
    check(respValid == 0, "R9 response single pulse", {31'b0, respValid}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++; checkCount++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    int ops0, wr0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(reqReady == 1, "R10 ready", {31'b0, reqReady}, 1);
    check(respValid == 0 && dnValid == 0 && dnLock == 0, "R10 idle outputs",
          {29'b0, respValid, dnValid, dnLock}, 0);
    rstN = 1;
    @(negedge clk);

    // R6 passthrough
    send(32'h4002_5040, 1, 32'h0, 0, 0, "R6 pass write");
    check(mem[32'h4002_5040] == 0, "R6 pass write stored", mem[32'h4002_5040], 0);
    send(32'h400F_FFFC, 1, 32'hA5A5_5A5A, 0, 0, "R6 pass write high");
    send(32'h400F_FFFC, 0, 0, 32'hA5A5_5A5A, 0, "R6 pass read high");
    send(32'h4000_0100, 1, 32'hFFFF_FFFF, 0, 0, "R6 pass write ones");

    // R1 address arithmetic and R2 set
    check(aliasOf(32'h4002_5040, 4) == 32'h424A_0810, "R1 alias formula",
          aliasOf(32'h4002_5040, 4), 32'h424A_0810);
    ops0 = opCount; wr0 = wrCount;
    send(32'h424A_0810, 1, 32'h1, 0, 0, "R2 alias set");
    check(mem[32'h4002_5040] == 32'h10, "R2 only bit 4 set", mem[32'h4002_5040], 32'h10);
    check(opCount - ops0 == 2, "R2 read then write", opCount - ops0, 2);
    check(lastWrAddr == 32'h4002_5040, "R1 downstream word", lastWrAddr, 32'h4002_5040);
    // R5 back to back, locked
    check(wrCyc == rdCyc + 2, "R5 write follows read ack", wrCyc, rdCyc + 2);
    check(rdLock && wrLock, "R5 lock on both", {30'b0, rdLock, wrLock}, 3);

    // R3 clear with upper data bits set, bit 31 (lane 3, bit 7)
    send(aliasOf(32'h4000_0103, 7), 1, 32'hFFFF_FFFE, 0, 0, "R3 alias clear");
    check(mem[32'h4000_0100] == 32'h7FFF_FFFF, "R3 clear bit 31", mem[32'h4000_0100], 32'h7FFF_FFFF);
    send(aliasOf(32'h4000_0101, 0), 1, 32'h0000_0002, 0, 0, "R3 alias clear data 2");
    check(mem[32'h4000_0100] == 32'h7FFF_FEFF, "R3 clear bit 8", mem[32'h4000_0100], 32'h7FFF_FEFF);

    // R4 alias reads
    ops0 = opCount; wr0 = wrCount;
    send(aliasOf(32'h4000_0103, 7), 0, 0, 0, 0, "R4 alias read cleared");
    send(aliasOf(32'h4000_0100, 3), 0, 0, 1, 0, "R4 alias read set");
    check(opCount - ops0 == 2 && wrCount == wr0, "R4 reads only", opCount - ops0, 2);
    send(aliasOf(32'h400F_FFFF, 7), 0, 0, 1, 0, "R1 R4 last bit of region");
    check(aliasOf(32'h400F_FFFF, 7) == 32'h43FF_FFFC, "R1 window top", aliasOf(32'h400F_FFFF, 7), 32'h43FF_FFFC);

    // R8 low bits ignored
    send(aliasOf(32'h4002_5040, 5) + 3, 1, 32'h1, 0, 0, "R8 alias set low bits 3");
    check(mem[32'h4002_5040] == 32'h30, "R8 bit 5 set", mem[32'h4002_5040], 32'h30);
    send(aliasOf(32'h4002_5040, 5) + 2, 0, 0, 1, 0, "R8 alias read low bits 2");
    send(32'h4002_5040, 0, 0, 32'h30, 0, "R6 pass read back");

    // R7 errors
    ops0 = opCount;
    send(32'h5000_0000, 1, 32'hFFFF_FFFF, 0, 1, "R7 high address");
    send(32'h4400_0000, 0, 0, 0, 1, "R7 past alias window");
    send(32'h3FFF_FFFC, 0, 0, 0, 1, "R7 below region");
    send(32'h4010_0000, 0, 0, 0, 1, "R7 past region");
    check(opCount == ops0, "R7 no downstream access", opCount - ops0, 0);

    repeat (3) @(negedge clk);
    check(expData.size() == 0, "R9 all responses seen", expData.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule